// File: doc/BRIEF.md
# Signed Completion Counter Bank

This block holds a bank of small counters that producers and software update through a plain register write port. Every write word does one of two things. It either loads a counter with an absolute value, or it adds a signed amount to the counter's current value. A mode bit in the word chooses which. A producer signals that a job is done by adding one. Software clears a counter by loading zero. A companion monitor block watches all counter values at once. That monitor gives back what it has consumed by writing a minus-one word through a second, dedicated write lane.

The value field and its sign flag together form a 16-bit two's-complement amount. A single word can therefore mean +1, -1 or any absolute value. Counters wrap and never saturate. Reads return the selected counter zero-extended to the bus width. When the bus and the monitor lane hit the same counter in one cycle, the bus write wins that cycle. The monitor write is held in a one-entry slot and lands on a following cycle. The monitor must not issue a new write while a held write is still waiting behind a repeated bus clash.

Top module: `sob_counter_bank`

## Requirements
- R1: While reset is asserted every counter is zero, and the first cycle after reset shows all counters at zero.
- R2: Counter k sits at byte address 4*k. Address bits 1:0 are ignored. A bus write to a slot at or above NUM_CNT changes no counter, and a read of such a slot returns zero.
- R3: A write word with bit 31 clear loads the counter with bits 14:0 of the word. Bits 30:16 have no effect.
- R4: A write word with bit 31 set adds the 16-bit two's-complement amount {bit 15, bits 14:0} to the counter, modulo 2^15.
- R5: The word 0x8000FFFF lowers a counter by exactly one, and it takes 0 to 0x7FFF.
- R6: Addition wraps without saturation. For example, 0x7FFF plus one gives 0.
- R7: The read port returns the addressed counter in bits 14:0, with bits 31:15 zero.
- R8: A monitor-lane write uses the same word encoding and is applied at the next clock edge when no bus write targets the same counter.
- R9: If a bus write and a monitor write target the same counter in one cycle, the bus write is applied at that edge and the monitor write at the following edge, on top of the bus result.
- R10: A bus write and a monitor write to different counters in one cycle are both applied at the same edge.
- R11: A write changes only the counter it addresses, so at most two counters change in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wr_addr | input | BUS_AW | Bus write byte address |
| bus_wr_data | input | 32 | Bus write word (mode bit 31, sign bit 15, value 14:0) |
| bus_rd_addr | input | BUS_AW | Bus read byte address |
| bus_rd_data | output | 32 | Zero-extended counter value, combinational |
| mon_wr_en | input | 1 | Monitor lane write strobe |
| mon_wr_id | input | IDX_W | Monitor lane counter index |
| mon_wr_data | input | 32 | Monitor lane write word, same encoding as the bus |
| cnt_flat | output | NUM_CNT*CNT_W | All counter values, counter k in bits k*CNT_W upward |

## Verification
The checker verifies four properties on every cycle. First, each in-range bus write leaves its counter at the loaded value or at the wrapped sum. Second, the read port's upper bits stay zero. Third, out-of-range reads return zero. Fourth, no more than two counters move in a cycle and reset clears the bank. Only the bench scenarios can show the deferral order for clashes between the bus and the monitor lane, the monitor lane's own updates, and the exact wrap points at 0 and 0x7FFF. The bench shows these by sweeping loads and signed increments over every counter against an arithmetic model.

// File: rtl/sob_pkg.sv
package sob_pkg;
   localparam int WORD_W   = 32;
   localparam int INC_POS  = 31;
   localparam int SIGN_POS = 15;
   localparam int MAG_W    = 15;
   localparam int MIN_CNT_W = MAG_W;
endpackage

// File: rtl/sob_word_decode.sv
module sob_word_decode
   import sob_pkg::*;
#(
   parameter int CNT_W = 15
) (
   input  logic [WORD_W-1:0] word_i,
   output logic              inc_o,
   output logic [CNT_W-1:0]  opnd_o
);
   // signed 16-bit amount formed by sign flag and magnitude field
   logic [MAG_W:0] sval;
   logic           unused_bits;

   assign sval        = {word_i[SIGN_POS], word_i[MAG_W-1:0]};
   assign inc_o       = word_i[INC_POS];
   assign unused_bits = ^{word_i[INC_POS-1:SIGN_POS+1], sval[MAG_W]};

   generate
      if (CNT_W <= MAG_W + 1) begin : g_trunc
         assign opnd_o = sval[CNT_W-1:0];
      end else begin : g_sext
         assign opnd_o = {{(CNT_W-MAG_W-1){sval[MAG_W]}}, sval};
      end
   endgenerate
endmodule

// File: rtl/sob_mon_defer.sv
module sob_mon_defer #(
   parameter int IDX_W = 3,
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mon_v_i,
   input  logic [IDX_W-1:0] mon_idx_i,
   input  logic             mon_inc_i,
   input  logic [CNT_W-1:0] mon_opnd_i,
   input  logic             bus_v_i,
   input  logic [IDX_W-1:0] bus_idx_i,
   output logic             lane_v_o,
   output logic [IDX_W-1:0] lane_idx_o,
   output logic             lane_inc_o,
   output logic [CNT_W-1:0] lane_opnd_o
);
   logic             pend_v;
   logic [IDX_W-1:0] pend_idx;
   logic             pend_inc;
   logic [CNT_W-1:0] pend_opnd;
   logic             cand_v;
   logic             clash;

   // a held write goes ahead of any new monitor write
   assign cand_v      = pend_v | mon_v_i;
   assign lane_idx_o  = pend_v ? pend_idx  : mon_idx_i;
   assign lane_inc_o  = pend_v ? pend_inc  : mon_inc_i;
   assign lane_opnd_o = pend_v ? pend_opnd : mon_opnd_i;
   assign clash       = cand_v && bus_v_i && (lane_idx_o == bus_idx_i);
   assign lane_v_o    = cand_v && !clash;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_idx  <= '0;
         pend_inc  <= 1'b0;
         pend_opnd <= '0;
      end else if (clash) begin
         pend_v    <= 1'b1;
         pend_idx  <= lane_idx_o;
         pend_inc  <= lane_inc_o;
         pend_opnd <= lane_opnd_o;
      end else if (pend_v && mon_v_i) begin
         pend_v    <= 1'b1;
         pend_idx  <= mon_idx_i;
         pend_inc  <= mon_inc_i;
         pend_opnd <= mon_opnd_i;
      end else begin
         pend_v    <= 1'b0;
      end
   end
endmodule

// File: rtl/sob_cell.sv
module sob_cell #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel_i,
   input  logic             bus_inc_i,
   input  logic [CNT_W-1:0] bus_opnd_i,
   input  logic             lane_sel_i,
   input  logic             lane_inc_i,
   input  logic [CNT_W-1:0] lane_opnd_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             use_inc;
   logic [CNT_W-1:0] opnd;

   always_comb begin
      use_inc = bus_sel_i ? bus_inc_i  : lane_inc_i;
      opnd    = bus_sel_i ? bus_opnd_i : lane_opnd_i;
      cnt_d   = cnt_q;
      if (bus_sel_i || lane_sel_i) begin
         cnt_d = use_inc ? (cnt_q + opnd) : opnd;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/sob_counter_bank.sv
module sob_counter_bank
   import sob_pkg::*;
#(
   parameter int NUM_CNT = 8,
   parameter int CNT_W   = 15,
   parameter int BUS_AW  = 8,
   localparam int IDX_W  = $clog2(NUM_CNT)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr_en,
   input  logic [BUS_AW-1:0]        bus_wr_addr,
   input  logic [31:0]              bus_wr_data,
   input  logic [BUS_AW-1:0]        bus_rd_addr,
   output logic [31:0]              bus_rd_data,
   input  logic                     mon_wr_en,
   input  logic [IDX_W-1:0]         mon_wr_id,
   input  logic [31:0]              mon_wr_data,
   output logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
   localparam int SLOT_W = BUS_AW - 2;
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CNT - 1);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_CNT - 1);

   initial begin
      assert (NUM_CNT >= 2) else $fatal(1, "NUM_CNT must be at least 2");
      assert (CNT_W >= MIN_CNT_W && CNT_W <= WORD_W)
         else $fatal(1, "CNT_W out of range");
      assert (SLOT_W >= IDX_W) else $fatal(1, "BUS_AW too narrow for NUM_CNT");
   end

   logic [SLOT_W-1:0] wr_slot, rd_slot;
   logic              bus_hit, mon_hit, rd_hit;
   logic [IDX_W-1:0]  bus_idx, rd_idx;
   logic              bus_inc, mon_inc;
   logic [CNT_W-1:0]  bus_opnd, mon_opnd;
   logic              lane_v, lane_inc;
   logic [IDX_W-1:0]  lane_idx;
   logic [CNT_W-1:0]  lane_opnd;
   logic [CNT_W-1:0]  cnt [NUM_CNT];
   logic [CNT_W-1:0]  rd_val;
   logic              unused_addr;

   assign wr_slot     = bus_wr_addr[BUS_AW-1:2];
   assign rd_slot     = bus_rd_addr[BUS_AW-1:2];
   assign bus_idx     = wr_slot[IDX_W-1:0];
   assign rd_idx      = rd_slot[IDX_W-1:0];
   assign bus_hit     = bus_wr_en && (wr_slot <= LAST_SLOT);
   assign rd_hit      = (rd_slot <= LAST_SLOT);
   assign mon_hit     = mon_wr_en && (mon_wr_id <= LAST_IDX);
   assign unused_addr = ^{bus_wr_addr[1:0], bus_rd_addr[1:0]};

   sob_word_decode #(.CNT_W(CNT_W)) u_dec_bus (
      .word_i(bus_wr_data), .inc_o(bus_inc), .opnd_o(bus_opnd));

   sob_word_decode #(.CNT_W(CNT_W)) u_dec_mon (
      .word_i(mon_wr_data), .inc_o(mon_inc), .opnd_o(mon_opnd));

   sob_mon_defer #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_defer (
      .clk(clk), .rst_n(rst_n),
      .mon_v_i(mon_hit), .mon_idx_i(mon_wr_id), .mon_inc_i(mon_inc), .mon_opnd_i(mon_opnd),
      .bus_v_i(bus_hit), .bus_idx_i(bus_idx),
      .lane_v_o(lane_v), .lane_idx_o(lane_idx), .lane_inc_o(lane_inc), .lane_opnd_o(lane_opnd));

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_cell
         sob_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .bus_sel_i(bus_hit && (bus_idx == IDX_W'(k))),
            .bus_inc_i(bus_inc), .bus_opnd_i(bus_opnd),
            .lane_sel_i(lane_v && (lane_idx == IDX_W'(k))),
            .lane_inc_i(lane_inc), .lane_opnd_i(lane_opnd),
            .cnt_o(cnt[k]));
         assign cnt_flat[k*CNT_W +: CNT_W] = cnt[k];
      end
   endgenerate

   assign rd_val = rd_hit ? cnt[rd_idx] : '0;

   generate
      if (CNT_W < WORD_W) begin : g_zext
         assign bus_rd_data = {{(WORD_W-CNT_W){1'b0}}, rd_val};
      end else begin : g_full
         assign bus_rd_data = rd_val;
      end
   endgenerate
endmodule

// File: rtl/sob_bank_chk.sv
module sob_bank_chk #(
   parameter int NUM_CNT = 8,
   parameter int CNT_W   = 15,
   parameter int BUS_AW  = 8,
   localparam int IDX_W  = $clog2(NUM_CNT)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_wr_en,
   input logic [BUS_AW-1:0]        bus_wr_addr,
   input logic [31:0]              bus_wr_data,
   input logic [BUS_AW-1:0]        bus_rd_addr,
   input logic [31:0]              bus_rd_data,
   input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
   localparam int SLOT_W = BUS_AW - 2;

   function automatic logic [CNT_W-1:0] amount(input logic [31:0] w);
      logic [31:0] s;
      s = {{16{w[15]}}, w[15:0]};
      return s[CNT_W-1:0];
   endfunction

   logic [SLOT_W-1:0]        w_slot, r_slot;
   logic [IDX_W-1:0]         w_idx, q_idx;
   logic                     w_in, q_chk, q_inc;
   logic [CNT_W-1:0]         cur, q_exp, cnt_at_q;
   logic [NUM_CNT*CNT_W-1:0] prev_flat;
   logic [NUM_CNT-1:0]       moved;
   logic                     unused_chk;

   assign w_slot     = bus_wr_addr[BUS_AW-1:2];
   assign r_slot     = bus_rd_addr[BUS_AW-1:2];
   assign w_idx      = w_slot[IDX_W-1:0];
   assign w_in       = bus_wr_en && (int'(w_slot) < NUM_CNT);
   assign cur        = cnt_flat[w_idx*CNT_W +: CNT_W];
   assign cnt_at_q   = cnt_flat[q_idx*CNT_W +: CNT_W];
   assign unused_chk = ^{bus_wr_addr[1:0], bus_rd_addr[1:0], bus_wr_data[30:16]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_chk <= 1'b0;
         q_inc <= 1'b0;
         q_idx <= '0;
         q_exp <= '0;
      end else begin
         q_chk <= w_in;
         q_inc <= bus_wr_data[31];
         q_idx <= w_idx;
         q_exp <= bus_wr_data[31] ? cur + amount(bus_wr_data) : amount(bus_wr_data);
      end
      prev_flat <= cnt_flat;
   end

   always_comb begin
      for (int k = 0; k < NUM_CNT; k++)
         moved[k] = cnt_flat[k*CNT_W +: CNT_W] != prev_flat[k*CNT_W +: CNT_W];
   end

   a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> cnt_flat == '0);

   a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      (q_chk && !q_inc) |-> cnt_at_q == q_exp);

   a_r4_inc_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (q_chk && q_inc) |-> cnt_at_q == q_exp);

   a_r2_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(r_slot) >= NUM_CNT) |-> bus_rd_data == '0);

   a_r11_two_movers: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(moved) <= 2);

   generate
      if (CNT_W < 32) begin : g_hi
         a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rd_data[31:CNT_W] == '0);
      end
   endgenerate
endmodule

bind sob_counter_bank sob_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .BUS_AW(BUS_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
   .bus_wr_data(bus_wr_data), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
   .cnt_flat(cnt_flat));

// File: tb/tb_sob_counter_bank.sv
module tb_sob_counter_bank;
   localparam int CLK_PERIOD = 40;
   localparam int NC = 8;
   localparam int CW = 15;
   localparam int AW = 8;
   localparam int IW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr_en = 1'b0;
   logic [AW-1:0]     bus_wr_addr = '0;
   logic [31:0]       bus_wr_data = '0;
   logic [AW-1:0]     bus_rd_addr = '0;
   logic [31:0]       bus_rd_data;
   logic              mon_wr_en = 1'b0;
   logic [IW-1:0]     mon_wr_id = '0;
   logic [31:0]       mon_wr_data = '0;
   logic [NC*CW-1:0]  cnt_flat;

   int n_run = 0;
   int n_fail = 0;
   logic [14:0] exp_c [NC];
   logic [31:0] seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   sob_counter_bank #(.NUM_CNT(NC), .CNT_W(CW), .BUS_AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
      .bus_wr_data(bus_wr_data), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
      .mon_wr_en(mon_wr_en), .mon_wr_id(mon_wr_id), .mon_wr_data(mon_wr_data),
      .cnt_flat(cnt_flat));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_run++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   function automatic logic [14:0] apply(input logic [14:0] c, input logic [31:0] w);
      logic [15:0] s;
      if (w[31]) begin
         s = {1'b0, c} + w[15:0];
         return s[14:0];
      end
      return w[14:0];
   endfunction

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   task automatic check_flat(input string tag);
      for (int k = 0; k < NC; k++)
         chk(tag, 32'(cnt_flat[k*CW +: CW]), 32'(exp_c[k]));
   endtask

   task automatic check_rd(input string tag, input logic [AW-1:0] addr, input logic [31:0] expv);
      bus_rd_addr = addr;
      #1;
      chk(tag, bus_rd_data, expv);
   endtask

   task automatic bus_wr(input logic [AW-1:0] addr, input logic [31:0] data);
      bus_wr_en = 1'b1; bus_wr_addr = addr; bus_wr_data = data;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic mon_wr(input logic [IW-1:0] id, input logic [31:0] data);
      mon_wr_en = 1'b1; mon_wr_id = id; mon_wr_data = data;
      @(negedge clk);
      mon_wr_en = 1'b0;
   endtask

   task automatic both_wr(input logic [AW-1:0] addr, input logic [31:0] bdata,
                          input logic [IW-1:0] id, input logic [31:0] mdata);
      bus_wr_en = 1'b1; bus_wr_addr = addr; bus_wr_data = bdata;
      mon_wr_en = 1'b1; mon_wr_id = id; mon_wr_data = mdata;
      @(negedge clk);
      bus_wr_en = 1'b0; mon_wr_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int k = 0; k < NC; k++) exp_c[k] = '0;
      repeat (3) @(negedge clk);
      check_flat("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_flat("R1 after reset");

      // R3: loads with junk in bits 30:16, R7 read-back zero extension
      for (int k = 0; k < NC; k++) begin
         logic [31:0] w;
         w = 32'h5A5A_0000 | 32'((k * 16'h0F1F + 16'h0123) & 16'hFFFF);
         w[31] = 1'b0;
         bus_wr(AW'(k*4), w);
         exp_c[k] = apply(exp_c[k], w);
         check_flat("R3 load");
      end
      for (int k = 0; k < NC; k++) check_rd("R7 readback", AW'(k*4), 32'(exp_c[k]));

      // R4/R11: mixed sweep of loads and signed increments
      for (int i = 0; i < 600; i++) begin
         logic [31:0] w;
         int k;
         w = rnd();
         k = int'(w[26:24]) % NC;
         w[31] = (i % 5) != 0;
         bus_wr(AW'(k*4), w);
         exp_c[k] = apply(exp_c[k], w);
         check_flat(w[31] ? "R4 inc" : "R3 load");
      end

      // R5: decrement by one, including 0 wrap
      bus_wr(AW'(6*4), 32'h0000_0000); exp_c[6] = '0;
      bus_wr(AW'(6*4), 32'h8000_FFFF);
      chk("R5 dec from 0", 32'(cnt_flat[6*CW +: CW]), 32'h7FFF);
      bus_wr(AW'(6*4), 32'h8000_FFFF);
      chk("R5 dec again", 32'(cnt_flat[6*CW +: CW]), 32'h7FFE);
      bus_wr(AW'(6*4), 32'h0000_0005);
      bus_wr(AW'(6*4), 32'h8000_FFFF);
      chk("R5 dec 5", 32'(cnt_flat[6*CW +: CW]), 32'h4);
      exp_c[6] = 15'h4;

      // R6: wrap on overflow
      bus_wr(AW'(7*4), 32'h0000_7FFF);
      bus_wr(AW'(7*4), 32'h8000_0001);
      chk("R6 wrap +1", 32'(cnt_flat[7*CW +: CW]), 32'h0);
      bus_wr(AW'(7*4), 32'h0000_7FF0);
      bus_wr(AW'(7*4), 32'h8000_0020);
      chk("R6 wrap +0x20", 32'(cnt_flat[7*CW +: CW]), 32'h10);
      exp_c[7] = 15'h10;
      check_flat("R11 others held");

      // R2: misaligned and out-of-range addresses
      bus_wr(AW'(3*4 + 3), 32'h0000_2222); exp_c[3] = 15'h2222;
      check_flat("R2 misaligned");
      bus_wr(AW'(NC*4), 32'h0000_1111);
      bus_wr(AW'(252), 32'h8000_0001);
      check_flat("R2 oob write");
      check_rd("R2 oob read", AW'(NC*4 + 8), 32'h0);
      check_rd("R7 readback 3", AW'(3*4 + 1), 32'h2222);

      // R8: monitor lane alone
      mon_wr(3'd1, 32'h0000_0100); exp_c[1] = 15'h100;
      check_flat("R8 mon load");
      mon_wr(3'd1, 32'h8000_FFFF); exp_c[1] = 15'hFF;
      check_flat("R8 mon dec");

      // R10: different counters in the same cycle
      both_wr(AW'(4*4), 32'h0000_0042, 3'd5, 32'h0000_0033);
      exp_c[4] = 15'h42; exp_c[5] = 15'h33;
      check_flat("R10 parallel");

      // R9: clash on one counter, bus first then monitor
      bus_wr(AW'(2*4), 32'h0000_000A);
      both_wr(AW'(2*4), 32'h8000_0005, 3'd2, 32'h8000_FFFF);
      exp_c[2] = 15'd15;
      check_flat("R9 bus first");
      @(negedge clk);
      exp_c[2] = 15'd14;
      check_flat("R9 mon next");
      both_wr(AW'(2*4), 32'h0000_0000, 3'd2, 32'h8000_0003);
      chk("R9 load then add", 32'(cnt_flat[2*CW +: CW]), 32'h0);
      @(negedge clk);
      chk("R9 deferred add", 32'(cnt_flat[2*CW +: CW]), 32'h3);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule